// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Pre-Timeout

This peripheral is a watchdog timer that sits on a simple 32-bit register bus. A 32-bit down-counter runs from the system clock and loses one each cycle while the block is enabled. Software keeps the system alive by reloading the counter before it runs out. Two interrupt lines are provided. The pre-timeout line fires when the remaining count falls to a programmable threshold, which gives software an early warning. The expiry line fires when the count reaches zero. Each line follows a sticky status flag, and software clears both flags with one write.

Every write is protected against stray stores. A write only takes effect when the bus write just before it put the unlock key into the key register. Each key write arms exactly one following write. A read neither needs the arming nor uses it up, so software can read the count or the status freely.

Register addresses (byte offsets on `bus_addr`): counter 0x00, threshold 0x04, enable 0x08, key 0x0C, status 0x10.

Top module: `wdk_timer`

## Requirements
- R1: After reset the enable bit is 0, the counter reads 0xFFFFFFFF, the threshold reads 0, the status reads 0, the key register reads 0 (not armed), and both interrupt lines are low.
- R2: A write to the counter (0x00), threshold (0x04), enable (0x08) or status (0x10) register has no effect unless the bus write just before it stored 0xF1D0DEAD to the key register (0x0C). Reading the key register returns the armed state in bit 0.
- R3: The next bus write of any kind clears the armed state: a write to another address (valid or not) and a key write of a wrong value both disarm, and a correct key write arms again. Reads do not change the armed state.
- R4: An armed write of a nonzero value to the counter register loads the counter with that value, and this reload is the keep-alive. An armed write of 0 leaves the counter unchanged. Reading 0x00 returns the remaining count.
- R5: Bit 0 of the enable register (0x08) selects counting. While it is 1, the count drops by exactly one per clock. While it is 0, the count holds its value.
- R6: Once the count reaches 0 it stays at 0 and never wraps. Only a reload moves it away from 0.
- R7: The pre-timeout flag (status bit 8, driving `irq_pre`) sets on the clock edge where a decrement brings the count to a nonzero threshold value.
- R8: A threshold of 0 never sets the pre-timeout flag. Only the expiry flag can then fire.
- R9: The expiry flag (status bit 9, driving `irq_expire`) sets on the clock edge where a decrement brings the count to 0. It stays set until it is cleared.
- R10: An armed write to the status register whose data has bits 9 and 8 both set clears both flags. Any other data pattern leaves them unchanged. A new event in the same cycle as a clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the count clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pre | output | 1 | Pre-timeout interrupt, level |
| irq_expire | output | 1 | Expiry interrupt, level |

## Verification
The assertions check the following on every cycle:
- A locked write leaves the threshold and enable unchanged.
- Any non-key write disarms the block, and a read leaves the armed state alone.
- While running, the count drops by exactly one. While stopped, it holds. At zero, it stays at zero.
- The expiry flag stays set until cleared, and a full clear empties both flags.
- A rise of the pre-timeout flag follows a nonzero threshold and coincides with the count equal to that threshold.

Only the bench's scenarios can show the following:
- The sequence of the locking rules across several writes.
- The full path from loading a count to the first interrupt.
- The keep-alive sequence that holds off expiry.
- That a partial clear pattern or a zero load is ignored.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_COUNT  = 5'h00;
  localparam logic [ADDR_W-1:0] A_THRESH = 5'h04;
  localparam logic [ADDR_W-1:0] A_ENABLE = 5'h08;
  localparam logic [ADDR_W-1:0] A_KEY    = 5'h0C;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'h10;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hF1D0DEAD;
  localparam int PRE_BIT = 8;
  localparam int EXP_BIT = 9;

  // Next value of a running or stopped counter that saturates at zero.
  function automatic logic [DATA_W-1:0] count_step(logic [DATA_W-1:0] c, logic run);
    return (run && (c != '0)) ? c - DATA_W'(1) : c;
  endfunction

  // True when this cycle's decrement lands exactly on target.
  function automatic logic lands_on(logic [DATA_W-1:0] c, logic run,
                                    logic [DATA_W-1:0] target);
    return run && (c != '0) && ((c - DATA_W'(1)) == target);
  endfunction
endpackage

// File: rtl/wdk_unlock.sv
module wdk_unlock
  import wdk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed,
  output logic              commit
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed_q <= 1'b0;
    else if (wr_en)
      armed_q <= (addr == A_KEY) && (wdata == UNLOCK_KEY);
  end

  assign armed  = armed_q;
  assign commit = wr_en && armed_q && (addr != A_KEY);

  // R3: any write other than the key uses up the arming
  p_arm_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_KEY) |=> !armed);

  // R3: reads never touch the arming
  p_read_keeps_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(armed));
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
  import wdk_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_COUNT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic              run,
  input  logic [DATA_W-1:0] threshold,
  output logic [DATA_W-1:0] count,
  output logic              hit_thresh,
  output logic              hit_zero
);
  logic [DATA_W-1:0] count_q;
  logic              take_load;

  assign take_load = load_en && (load_val != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= RESET_COUNT;
    else if (take_load)
      count_q <= load_val;
    else
      count_q <= count_step(count_q, run);
  end

  assign count      = count_q;
  assign hit_zero   = !take_load && lands_on(count_q, run, '0);
  assign hit_thresh = !take_load && (threshold != '0) && lands_on(count_q, run, threshold);

  // R6: zero is a floor
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load_en) |=> count == '0);

  // R5: stopped count holds
  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_en) |=> $stable(count));

  // R5: running count drops by one
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count != '0 && !load_en) |=> count == $past(count) - DATA_W'(1));
endmodule

// File: rtl/wdk_irq_status.sv
module wdk_irq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_pre,
  input  logic       set_exp,
  input  logic       clear,
  output logic [1:0] flags
);
  logic [1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= 2'b00;
    else
      flags_q <= (clear ? 2'b00 : flags_q) | {set_exp, set_pre};
  end

  assign flags = flags_q;

  // R9: expiry flag is sticky until cleared
  p_expire_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !clear) |=> flags[1]);

  // R10: a clear with no new event empties both flags
  p_clear_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !set_pre && !set_exp) |=> flags == 2'b00);
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer
  import wdk_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_COUNT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pre,
  output logic              irq_expire
);
  logic              armed, commit;
  logic              en_q;
  logic [DATA_W-1:0] thresh_q;
  logic [DATA_W-1:0] count;
  logic              hit_thresh, hit_zero;
  logic [1:0]        flags;
  logic              wr_count, wr_thresh, wr_enable, clr_status;

  wdk_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .armed(armed), .commit(commit)
  );

  assign wr_count   = commit && (bus_addr == A_COUNT);
  assign wr_thresh  = commit && (bus_addr == A_THRESH);
  assign wr_enable  = commit && (bus_addr == A_ENABLE);
  assign clr_status = commit && (bus_addr == A_STATUS) &&
                      bus_wdata[EXP_BIT] && bus_wdata[PRE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      thresh_q <= '0;
    end else begin
      if (wr_enable) en_q     <= bus_wdata[0];
      if (wr_thresh) thresh_q <= bus_wdata;
    end
  end

  wdk_counter #(.RESET_COUNT(RESET_COUNT)) u_counter (
    .clk(clk), .rst_n(rst_n), .load_en(wr_count), .load_val(bus_wdata),
    .run(en_q), .threshold(thresh_q), .count(count),
    .hit_thresh(hit_thresh), .hit_zero(hit_zero)
  );

  wdk_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .set_pre(hit_thresh), .set_exp(hit_zero),
    .clear(clr_status), .flags(flags)
  );

  assign irq_pre    = flags[0];
  assign irq_expire = flags[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_COUNT:  bus_rdata = count;
      A_THRESH: bus_rdata = thresh_q;
      A_ENABLE: bus_rdata[0] = en_q;
      A_KEY:    bus_rdata[0] = armed;
      A_STATUS: begin
        bus_rdata[PRE_BIT] = flags[0];
        bus_rdata[EXP_BIT] = flags[1];
      end
      default:  bus_rdata = '0;
    endcase
  end

  // R2: a locked write changes no setting
  p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !armed) |=> ($stable(thresh_q) && $stable(en_q)));

  // R8: pre-timeout only rises under a nonzero threshold
  p_pre_needs_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pre) |-> $past(thresh_q) != '0);

  // R7: pre-timeout rises as the count lands on the threshold
  p_pre_at_thr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_pre) && $stable(thresh_q)) |-> count == thresh_q);
endmodule

// File: tb/tb_wdk_timer.sv
module tb_wdk_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam logic [31:0] KEY = 32'hF1D0DEAD;
  localparam logic [4:0] R_CNT = 5'h00, R_THR = 5'h04, R_EN = 5'h08,
                         R_KEY = 5'h0C, R_STAT = 5'h10, R_BAD = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pre, irq_expire;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  wdk_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pre(irq_pre), .irq_expire(irq_expire)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG_CYCLES) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d",
               cycles, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic kwr(logic [4:0] a, logic [31:0] d);
    wr(R_KEY, KEY);
    wr(a, d);
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(R_CNT, v);  check("R1 count", v, 32'hFFFFFFFF);
    rd(R_THR, v);  check("R1 threshold", v, 0);
    rd(R_EN, v);   check("R1 enable", v, 0);
    rd(R_STAT, v); check("R1 status", v, 0);
    rd(R_KEY, v);  check("R1 armed", v, 0);
    check("R1 irq lines", {30'b0, irq_expire, irq_pre}, 0);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    wr(R_CNT, 32'h55);
    rd(R_CNT, v); check("R2 locked count write", v, 32'hFFFFFFFF);
    wr(R_EN, 1);
    rd(R_EN, v);  check("R2 locked enable write", v, 0);
    wr(R_THR, 9);
    rd(R_THR, v); check("R2 locked threshold write", v, 0);
  endtask

  task automatic t_arming();
    logic [31:0] v;
    wr(R_KEY, 32'h12345678);
    rd(R_KEY, v); check("R3 wrong key not armed", v, 0);
    wr(R_KEY, KEY);
    rd(R_KEY, v); check("R2 key arms", v, 1);
    idle(3);
    rd(R_CNT, v); rd(R_KEY, v); check("R3 reads keep arming", v, 1);
    wr(R_BAD, 32'h0);
    rd(R_KEY, v); check("R3 invalid address consumes arming", v, 0);
    wr(R_CNT, 32'h66);
    rd(R_CNT, v); check("R3 write after consumed arming ignored", v, 32'hFFFFFFFF);
    wr(R_KEY, KEY);
    wr(R_KEY, 32'h0);
    rd(R_KEY, v); check("R3 wrong key disarms", v, 0);
    wr(R_KEY, KEY);
    wr(R_KEY, KEY);
    wr(R_THR, 3);
    rd(R_THR, v); check("R3 rearm then threshold write", v, 3);
    rd(R_KEY, v); check("R3 armed write consumes arming", v, 0);
  endtask

  task automatic t_load_hold();
    logic [31:0] v;
    kwr(R_CNT, 100);
    rd(R_CNT, v); check("R4 load value", v, 100);
    idle(8);
    rd(R_CNT, v); check("R5 hold while disabled", v, 100);
    kwr(R_CNT, 0);
    rd(R_CNT, v); check("R4 zero load ignored", v, 100);
  endtask

  task automatic t_pre_and_expire();
    logic [31:0] v;
    bit seen;
    int n1, n2;
    kwr(R_THR, 5);
    kwr(R_CNT, 20);
    kwr(R_EN, 1);
    rd(R_EN, v); check("R5 enable set", v, 1);
    rd(R_CNT, v); n1 = v; idle(4);
    rd(R_CNT, v); n2 = v;
    check("R5 decrement one per clock", n1 - n2, 4);
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (irq_pre) seen = 1; else @(negedge clk);
    end
    check("R7 pre irq raised", seen, 1);
    rd(R_CNT, v); check("R7 count at threshold when pre rises", v, 5);
    check("R9 no expiry yet", irq_expire, 0);
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (irq_expire) seen = 1; else @(negedge clk);
    end
    check("R9 expiry raised", seen, 1);
    rd(R_CNT, v); check("R9 count zero at expiry", v, 0);
    idle(10);
    rd(R_CNT, v); check("R6 stays at zero", v, 0);
    check("R9 expiry sticky", irq_expire, 1);
    rd(R_STAT, v); check("R7 R9 status bits 9:8", v, 32'h300);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    kwr(R_STAT, 32'h100);
    rd(R_STAT, v); check("R10 partial mask no clear", v, 32'h300);
    wr(R_STAT, 32'h300);
    rd(R_STAT, v); check("R10 locked clear ignored", v, 32'h300);
    kwr(R_STAT, 32'h300);
    rd(R_STAT, v); check("R10 full mask clears", v, 0);
    check("R10 irq lines low", {30'b0, irq_expire, irq_pre}, 0);
  endtask

  task automatic t_zero_thresh();
    bit pre_seen, exp_seen;
    kwr(R_THR, 0);
    kwr(R_CNT, 12);
    pre_seen = 0; exp_seen = 0;
    for (int i = 0; i < 40 && !exp_seen; i++) begin
      if (irq_pre) pre_seen = 1;
      if (irq_expire) exp_seen = 1; else @(negedge clk);
    end
    check("R8 expiry fires with zero threshold", exp_seen, 1);
    check("R8 no pre irq with zero threshold", {pre_seen, irq_pre}, 0);
    kwr(R_STAT, 32'h300);
  endtask

  task automatic t_keepalive();
    logic [31:0] v;
    bit exp_seen;
    exp_seen = 0;
    kwr(R_CNT, 40);
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 20; i++) begin
        if (irq_expire) exp_seen = 1;
        @(negedge clk);
      end
      kwr(R_CNT, 40);
    end
    check("R4 keep-alive prevents expiry", exp_seen, 0);
    rd(R_CNT, v); check("R4 reload restores count", (v > 30 && v <= 40), 1);
    kwr(R_EN, 0);
    rd(R_CNT, v);
    idle(10);
    begin
      logic [31:0] w;
      rd(R_CNT, w); check("R5 stop holds count", w, v);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_arming();
    t_load_hold();
    t_pre_and_expire();
    t_clear();
    t_zero_thresh();
    t_keepalive();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule